// File: doc/BRIEF.md
# Cache Parameter Self-Tuning Controller

This block is a controller that searches for a low-energy cache configuration while the system runs. It sets four cache settings: total capacity, line length, number of ways, and way prediction. For each candidate it asks for a cache flush and then a measurement interval. It then waits for an energy figure from an external meter and compares that figure with the lowest energy seen so far.

The search is greedy and changes one setting at a time. Capacity is tuned first, then line length, then associativity. Way prediction is tried last. Within a setting, the controller keeps stepping to the next larger value while the measured energy strictly drops. At the first value that is not better, it steps back to the previous value, which is the best one, and that value stays fixed for the rest of the search. The number of trials therefore grows with the sum of the value counts, not with their product. When the search ends, the controller holds the winning configuration on its outputs and raises a completion flag. It stays there until it is started again.

Each setting is an index from 0 to `NUM_VALS-1`. With the default of three values, the encodings are as follows. Capacity 0/1/2 means 2/4/8 KB. Line 0/1/2 means 16/32/64 bytes. Ways 0/1/2 means 1/2/4 ways.

Top module: `cache_tuner`

## Requirements
- R1: After reset, sizeSel, lineSel, waySel, wayPred, evalCount, flushReq, measureReq and done are all 0.
- R2: A start seen while idle or done loads the first candidate: sizeSel=0 (2 KB), lineSel=0 (16 B), waySel=0 (1 way), wayPred=0. It also clears evalCount and the recorded best energy, and clears done.
- R3: Every candidate produces exactly one flushReq cycle, which starts the cycle after the configuration changes. It is followed the next cycle by exactly one measureReq cycle. The controller then waits for energyValid, however long that takes.
- R4: Capacity is searched first, in increasing index order. The first measurement always becomes the best. After that, the index advances only while each new energy is strictly lower than the best. At the first result that is not lower, or when the last index is better, the best capacity is kept.
- R5: Line length is searched next, and then ways, by the same rule. The first step of each starts at index 1, with all settings fixed earlier held at their best values.
- R6: Way prediction is tried (wayPred=1) only when the chosen number of ways is above one (waySel>0). It stays on only if that energy is strictly lower than the best. Otherwise it returns to 0 and the search ends.
- R7: evalCount increases by one for each accepted energy result. With three values per setting it never exceeds 8.
- R8: When done=1, the configuration and evalCount stay constant and no flush or measure request is made. Any energyValid is ignored until the next start.
- R9: energyValid is ignored except while the controller is waiting for a result. start is ignored except while the controller is idle or done.
- R10: An energy equal to the best is treated as not lower.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search |
| energyValid | input | 1 | energyIn carries a measurement result this cycle |
| energyIn | input | ENERGY_W | Energy measured for the current candidate |
| sizeSel | output | SEL_W | Capacity index (0=2 KB, 1=4 KB, 2=8 KB) |
| lineSel | output | SEL_W | Line length index (0=16 B, 1=32 B, 2=64 B) |
| waySel | output | SEL_W | Associativity index (0=1, 1=2, 2=4 ways) |
| wayPred | output | 1 | Way prediction enable |
| flushReq | output | 1 | One-cycle request to flush the cache |
| measureReq | output | 1 | One-cycle request to start a measurement interval |
| done | output | 1 | Search finished; best configuration held |
| evalCount | output | EVAL_W | Number of configurations evaluated |

## Verification
The hardest paths to reach from the ports depend on the energy landscape. One is a tie that ends a phase. Another is associativity settling back at one way, so that the prediction trial is skipped. A third is the last index of a setting winning, which must move to the next phase without stepping back. The bench drives energies from additive per-setting cost tables, chosen so that each scenario forces one of these turns. It also injects energy pulses during flush cycles and after completion, and a start while a measurement is pending. In every case, a behavioural model must agree on every cycle that these pulses change nothing.

// File: rtl/cache_tuner_pkg.sv
package cache_tuner_pkg;

  localparam int NUM_FIELDS = 3;
  localparam int FLD_SIZE   = 0;
  localparam int FLD_LINE   = 1;
  localparam int FLD_WAY    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_MEAS,
    ST_WAIT,
    ST_DONE
  } tuneState_t;

  typedef enum logic [1:0] {
    PH_SIZE = 2'd0,
    PH_LINE = 2'd1,
    PH_WAY  = 2'd2,
    PH_PRED = 2'd3
  } tunePhase_t;

  typedef struct packed {
    logic                  init;
    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] dec;
    logic                  setPred;
    logic                  clrPred;
    logic                  loadBest;
    logic                  countEval;
  } tuneStrobe_t;

endpackage

// File: rtl/cache_tuner_dp.sv
module cache_tuner_dp
  import cache_tuner_pkg::*;
#(
  parameter int NUM_VALS = 3,
  parameter int ENERGY_W = 24,
  parameter int SEL_W    = 2,
  parameter int EVAL_W   = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  tuneStrobe_t                          stb,
  input  logic [ENERGY_W-1:0]                  energyIn,
  output logic [NUM_FIELDS-1:0][SEL_W-1:0]     selOut,
  output logic [NUM_FIELDS-1:0]                atMax,
  output logic                                 wayAboveOne,
  output logic                                 better,
  output logic                                 wayPred,
  output logic [EVAL_W-1:0]                    evalCount
);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_VALS - 1);
  localparam logic [SEL_W-1:0] SEL_ONE = SEL_W'(1);

  logic [ENERGY_W-1:0] bestEnergy;
  logic                bestValid;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [SEL_W-1:0] selQ;
    always_ff @(posedge clk) begin
      if (!rstN)             selQ <= '0;
      else if (stb.init)     selQ <= '0;
      else if (stb.inc[f])   selQ <= selQ + SEL_ONE;
      else if (stb.dec[f])   selQ <= selQ - SEL_ONE;
    end
    assign selOut[f] = selQ;
    assign atMax[f]  = (selQ == SEL_MAX);
  end

  assign wayAboveOne = (selOut[FLD_WAY] > SEL_ONE);
  assign better      = !bestValid || (energyIn < bestEnergy);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestEnergy <= '0;
      bestValid  <= 1'b0;
    end else if (stb.init) begin
      bestEnergy <= '0;
      bestValid  <= 1'b0;
    end else if (stb.loadBest) begin
      bestEnergy <= energyIn;
      bestValid  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              wayPred <= 1'b0;
    else if (stb.init)      wayPred <= 1'b0;
    else if (stb.setPred)   wayPred <= 1'b1;
    else if (stb.clrPred)   wayPred <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              evalCount <= '0;
    else if (stb.init)      evalCount <= '0;
    else if (stb.countEval) evalCount <= evalCount + EVAL_W'(1);
  end

endmodule

// File: rtl/cache_tuner_ctrl.sv
module cache_tuner_ctrl
  import cache_tuner_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  energyValid,
  input  logic                  better,
  input  logic [NUM_FIELDS-1:0] atMax,
  input  logic                  wayAboveOne,
  output tuneStrobe_t           stb,
  output logic                  flushReq,
  output logic                  measureReq,
  output logic                  done
);

  tuneState_t stateQ, stateD;
  tunePhase_t phaseQ, phaseD;
  logic [1:0] fld;

  assign fld = phaseQ;

  always_comb begin
    stateD = stateQ;
    phaseD = phaseQ;
    stb    = '0;
    case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stb.init = 1'b1;
          phaseD   = PH_SIZE;
          stateD   = ST_APPLY;
        end
      end
      ST_APPLY: stateD = ST_MEAS;
      ST_MEAS:  stateD = ST_WAIT;
      ST_WAIT: begin
        if (energyValid) begin
          stb.countEval = 1'b1;
          stb.loadBest  = better;
          if (phaseQ == PH_PRED) begin
            stb.clrPred = !better;
            stateD      = ST_DONE;
          end else if (better && !atMax[fld]) begin
            stb.inc[fld] = 1'b1;
            stateD       = ST_APPLY;
          end else begin
            stb.dec[fld] = !better;
            if (phaseQ == PH_WAY) begin
              if (better || wayAboveOne) begin
                stb.setPred = 1'b1;
                phaseD      = PH_PRED;
                stateD      = ST_APPLY;
              end else begin
                stateD = ST_DONE;
              end
            end else begin
              stb.inc[fld + 2'd1] = 1'b1;
              phaseD = tunePhase_t'(phaseQ + 2'd1);
              stateD = ST_APPLY;
            end
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= PH_SIZE;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

  assign flushReq   = (stateQ == ST_APPLY);
  assign measureReq = (stateQ == ST_MEAS);
  assign done       = (stateQ == ST_DONE);

endmodule

// File: rtl/cache_tuner.sv
module cache_tuner
  import cache_tuner_pkg::*;
#(
  parameter  int NUM_VALS = 3,
  parameter  int ENERGY_W = 24,
  localparam int SEL_W    = $clog2(NUM_VALS),
  localparam int EVAL_W   = $clog2(3 * NUM_VALS + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                energyValid,
  input  logic [ENERGY_W-1:0] energyIn,
  output logic [SEL_W-1:0]    sizeSel,
  output logic [SEL_W-1:0]    lineSel,
  output logic [SEL_W-1:0]    waySel,
  output logic                wayPred,
  output logic                flushReq,
  output logic                measureReq,
  output logic                done,
  output logic [EVAL_W-1:0]   evalCount
);

  tuneStrobe_t                      stb;
  logic [NUM_FIELDS-1:0][SEL_W-1:0] selOut;
  logic [NUM_FIELDS-1:0]            atMax;
  logic                             wayAboveOne;
  logic                             better;

  cache_tuner_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .energyValid (energyValid),
    .better      (better),
    .atMax       (atMax),
    .wayAboveOne (wayAboveOne),
    .stb         (stb),
    .flushReq    (flushReq),
    .measureReq  (measureReq),
    .done        (done)
  );

  cache_tuner_dp #(
    .NUM_VALS (NUM_VALS),
    .ENERGY_W (ENERGY_W),
    .SEL_W    (SEL_W),
    .EVAL_W   (EVAL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .energyIn    (energyIn),
    .selOut      (selOut),
    .atMax       (atMax),
    .wayAboveOne (wayAboveOne),
    .better      (better),
    .wayPred     (wayPred),
    .evalCount   (evalCount)
  );

  assign sizeSel = selOut[FLD_SIZE];
  assign lineSel = selOut[FLD_LINE];
  assign waySel  = selOut[FLD_WAY];

endmodule

// File: rtl/cache_tuner_chk.sv
module cache_tuner_chk #(
  parameter  int NUM_VALS = 3,
  parameter  int ENERGY_W = 24,
  localparam int SEL_W    = $clog2(NUM_VALS),
  localparam int EVAL_W   = $clog2(3 * NUM_VALS + 2),
  localparam int EVAL_MAX = 3 * (NUM_VALS - 1) + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              energyValid,
  input logic [SEL_W-1:0]  sizeSel,
  input logic [SEL_W-1:0]  lineSel,
  input logic [SEL_W-1:0]  waySel,
  input logic              wayPred,
  input logic              flushReq,
  input logic              measureReq,
  input logic              done,
  input logic [EVAL_W-1:0] evalCount
);

  logic [EVAL_W-1:0] prevCount;
  always_ff @(posedge clk) begin
    if (!rstN) prevCount <= '0;
    else       prevCount <= evalCount;
  end

  AST_FLUSH_THEN_MEASURE: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> measureReq && !flushReq); // R3
  AST_MEASURE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    measureReq |=> !measureReq && !flushReq); // R3
  AST_PRED_NEEDS_WAYS: assert property (@(posedge clk) disable iff (!rstN)
    wayPred |-> waySel != '0); // R6
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sizeSel) < NUM_VALS) && (int'(lineSel) < NUM_VALS) && (int'(waySel) < NUM_VALS)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (evalCount == prevCount) || (evalCount == prevCount + EVAL_W'(1))); // R7
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    int'(evalCount) <= EVAL_MAX); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !flushReq && !measureReq); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(evalCount) && $stable(sizeSel) && $stable(lineSel)
                       && $stable(waySel) && $stable(wayPred)); // R8
  AST_NO_EVAL_OFF_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq || measureReq) |=> $stable(evalCount)); // R9

endmodule

bind cache_tuner cache_tuner_chk #(.NUM_VALS(NUM_VALS), .ENERGY_W(ENERGY_W)) u_chk (.*);

// File: tb/cache_tuner_bench.sv
`timescale 1ns/1ps
module cache_tuner_bench;

  localparam int NV  = 3;
  localparam int EW  = 24;
  localparam int SW  = $clog2(NV);
  localparam int CW  = $clog2(3 * NV + 2);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          energyValid = 1'b0;
  logic [EW-1:0] energyIn = '0;
  logic [SW-1:0] sizeSel, lineSel, waySel;
  logic          wayPred, flushReq, measureReq, done;
  logic [CW-1:0] evalCount;

  int errors = 0;
  int checks = 0;

  cache_tuner #(.NUM_VALS(NV), .ENERGY_W(EW)) u_cache_tuner (
    .clk(clk), .rstN(rstN), .start(start), .energyValid(energyValid), .energyIn(energyIn),
    .sizeSel(sizeSel), .lineSel(lineSel), .waySel(waySel), .wayPred(wayPred),
    .flushReq(flushReq), .measureReq(measureReq), .done(done), .evalCount(evalCount)
  );

  always #4 clk = ~clk;

  // cost tables: energy = sum of per-setting contributions
  int sE[3], lE[3], wE[3], pE[2];

  // behavioural reference: 0 idle, 1 flush, 2 measure, 3 wait, 4 done
  int mState = 0, mPhase = 0, mPred = 0, mCount = 0, mBest = 0, mBestValid = 0;
  int mSel[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPhase = 0; mPred = 0; mCount = 0; mBest = 0; mBestValid = 0;
      mSel = '{0, 0, 0};
    end else begin
      case (mState)
        0, 4: if (start) begin
          mSel = '{0, 0, 0}; mPred = 0; mCount = 0; mBestValid = 0; mPhase = 0; mState = 1;
        end
        1: mState = 2;
        2: mState = 3;
        3: if (energyValid) begin
          int e;
          bit win;
          e = int'(energyIn);
          win = (mBestValid == 0) || (e < mBest);
          mCount++;
          if (win) begin mBest = e; mBestValid = 1; end
          if (mPhase == 3) begin
            if (!win) mPred = 0;
            mState = 4;
          end else if (win && mSel[mPhase] < NV - 1) begin
            mSel[mPhase]++;
            mState = 1;
          end else begin
            if (!win) mSel[mPhase]--;
            if (mPhase < 2) begin
              mPhase++; mSel[mPhase]++; mState = 1;
            end else if (mSel[2] > 0) begin
              mPred = 1; mPhase = 3; mState = 1;
            end else begin
              mState = 4;
            end
          end
        end
        default: mState = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge after reset
  always @(negedge clk) begin
    if (rstN) begin
      check(flushReq == (mState == 1), "R3 flushReq", int'(flushReq), int'(mState == 1));
      check(measureReq == (mState == 2), "R3 measureReq", int'(measureReq), int'(mState == 2));
      check(done == (mState == 4), "R8 done", int'(done), int'(mState == 4));
      check(int'(sizeSel) == mSel[0], "R4 sizeSel", int'(sizeSel), mSel[0]);
      check(int'(lineSel) == mSel[1], "R5 lineSel", int'(lineSel), mSel[1]);
      check(int'(waySel) == mSel[2], "R5 waySel", int'(waySel), mSel[2]);
      check(int'(wayPred) == mPred, "R6 wayPred", int'(wayPred), mPred);
      check(int'(evalCount) == mCount, "R7 evalCount", int'(evalCount), mCount);
    end
  end

  function automatic int costNow();
    return sE[sizeSel] + lE[lineSel] + wE[waySel] + pE[wayPred];
  endfunction

  task automatic runSearch(input int delay, input bit noisy);
    bit pending = 0;
    int cnt = 0;
    @(negedge clk); start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0; energyValid = 1'b0;
      if (done) break;
      if (noisy && flushReq) begin energyValid = 1'b1; energyIn = '0; end // R9
      if (measureReq) begin
        pending = 1; cnt = delay;
      end else if (pending) begin
        if (noisy) start = 1'b1; // R9 start ignored while waiting
        if (cnt == 0) begin
          energyValid = 1'b1; energyIn = EW'(costNow()); pending = 0; start = 1'b0;
        end else cnt--;
      end
    end
  endtask

  task automatic expectFinal(input int s, input int l, input int w, input int p, input int n,
                             input string tag);
    check(int'(sizeSel) == s, {tag, " final size"}, int'(sizeSel), s);
    check(int'(lineSel) == l, {tag, " final line"}, int'(lineSel), l);
    check(int'(waySel) == w, {tag, " final ways"}, int'(waySel), w);
    check(int'(wayPred) == p, {tag, " final pred"}, int'(wayPred), p);
    check(int'(evalCount) == n, {tag, " final count"}, int'(evalCount), n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sizeSel == '0 && lineSel == '0 && waySel == '0, "R1 config reset", int'(sizeSel), 0);
    check(!wayPred && !flushReq && !measureReq && !done, "R1 flags reset", int'(done), 0);
    check(evalCount == '0, "R1 count reset", int'(evalCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !flushReq, "R9 idle without start", int'(flushReq), 0);

    // A: size peaks at 4 KB, line wins at max, tie on ways -> one way, pred skipped (R10, R6)
    sE = '{50, 40, 45}; lE = '{30, 20, 10}; wE = '{9, 9, 0}; pE = '{5, 0};
    runSearch(0, 0);
    expectFinal(1, 2, 0, 0, 6, "R10/R6 scenarioA");

    // R2 restart from done reloads initial candidate
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(sizeSel == '0 && lineSel == '0 && waySel == '0 && !wayPred, "R2 initial config",
          int'(sizeSel) + int'(lineSel) + int'(waySel), 0);
    check(evalCount == '0 && !done && flushReq, "R2 cleared and flushing", int'(evalCount), 0);
    // finish this search then run B with noise
    sE = '{10, 20, 30}; lE = '{10, 5, 8}; wE = '{10, 6, 2}; pE = '{3, 1};
    begin
      bit pend = 0;
      forever begin
        @(negedge clk); energyValid = 1'b0;
        if (done) break;
        if (measureReq) pend = 1;
        else if (pend) begin energyValid = 1'b1; energyIn = EW'(costNow()); pend = 0; end
      end
    end
    expectFinal(0, 1, 2, 1, 7, "R4/R5 restart");

    // B: 2 KB kept, line 32, 4 ways, pred kept; noisy inputs ignored (R9)
    runSearch(2, 1);
    expectFinal(0, 1, 2, 1, 7, "R9/R6 scenarioB");

    // R8 energy after done ignored
    @(negedge clk); energyValid = 1'b1; energyIn = '0;
    @(negedge clk); energyValid = 1'b0;
    @(negedge clk);
    expectFinal(0, 1, 2, 1, 7, "R8 hold");
    check(done && !flushReq && !measureReq, "R8 still done", int'(done), 1);

    // C: 8 KB wins at max, line stays 16, two ways, pred rejected (R4, R6)
    sE = '{30, 20, 10}; lE = '{5, 9, 9}; wE = '{8, 4, 6}; pE = '{0, 2};
    runSearch(1, 0);
    expectFinal(2, 0, 1, 0, 7, "R4/R6 scenarioC");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule